// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Ready Wait States

This block runs single read and write cycles on an external memory bus on behalf of an internal master. The internal side presents a request pulse with address, write data, byte enables and direction. The block then drives address, chip select, strobes and the address latch pulse on the external side. It reports the end of the cycle with a one-clock completion pulse, together with the captured read data. The two top address bits pick one of four chip-select regions.

Each region has two static settings. The first is a wait-enable flag. When it is 0, waits are on: software wait states are inserted and then the external ready input is honoured. When it is 1, the region runs a no-wait cycle and never looks at ready. The second is a two-bit software wait count. Ready is brought in through a two-flop synchronizer. It is examined only in the last strobe clock. While it reads low, the cycle is held with every bus output frozen.

A mode input selects a multiplexed address/data form or a separate-bus form. In multiplexed form the setup clock carries the low address bits on the data lines and pulses the address latch enable. Each bus-clock phase maps to one system clock in this implementation.

Top module: `ebus_wait_ctrl`

## Requirements
- R1: After reset, all chip selects, the read strobe, both write strobes and byte-high enable are high (inactive), the address latch enable is low and the completion pulse is low.
- R2: A cycle accepted from idle drives exactly one chip select low, cs_n[i] for region i = addr[AW-1:AW-2]. It stays low from the clock after acceptance until the clock that ends the cycle.
- R3: In a region whose wait_off bit is 1, the strobe phase lasts exactly one clock whatever the ready input does. The completion pulse appears two clocks after the clock in which the request was sampled.
- R4: In a region whose wait_off bit is 0, the strobe phase is stretched by software waits selected by wait_cnt[2i+1:2i]: 00 gives one, 01 gives two, and 10 and 11 both give three.
- R5: In a region with waits enabled, the cycle ends at the later of two points. One is the end of the software waits. The other is the second clock after ready is first seen high by the synchronizer's first flop. While ready stays low, further clocks are added.
- R6: While the strobe phase is held, the address, chip selects, strobes and byte-high enable keep their values clock after clock.
- R7: With mux_mode=1, the setup clock asserts ale with bus_doe=1 and the low DW address bits on bus_dout. No strobe is asserted in that clock; strobes follow only in later clocks.
- R8: With mux_mode=0, ale stays low for the whole cycle.
- R9: During the strobe phase, a read drives rd_n low with both write strobes high. A write drives wrl_n low if be[0]=1 and wrh_n low if be[1]=1, with rd_n high. Throughout the cycle bhe_n equals the inverse of be[1].
- R10: The completion pulse is high for exactly one clock, on the clock in which the strobes and chip select return high. For a read, rdata holds the bus_din value present in the last strobe clock.
- R11: A request raised while a cycle is in progress is ignored and starts no further cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Cycle request, sampled while idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Cycle address; top two bits select the region |
| wdata | input | DW | Write data |
| be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Captured read data |
| mux_mode | input | 1 | 1 = multiplexed address/data form, 0 = separate bus |
| wait_off | input | 4 | Per-region flag, 1 = no-wait cycles, ready ignored |
| wait_cnt | input | 8 | Per-region two-bit software wait code |
| rdy_in | input | 1 | Ready from slow device, low requests waits |
| bus_addr | output | AW | External address |
| bus_dout | output | DW | External data out (address low bits in mux setup) |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | DW | External data in |
| cs_n | output | 4 | Active-low chip selects |
| rd_n | output | 1 | Active-low read strobe |
| wrl_n | output | 1 | Active-low low-byte write strobe |
| wrh_n | output | 1 | Active-low high-byte write strobe |
| bhe_n | output | 1 | Active-low byte-high enable |
| ale | output | 1 | Address latch enable |

## Verification
The bench builds the block with AW=18 and DW=16. The narrower address still splits cleanly into four regions, and a random address reaches every chip select often. Per-cycle configuration is drawn at random, so every wait code meets both ready-held and ready-late timing in both bus forms. Directed cycles release ready before, at and after the end of the software waits, which places the two competing end points on either side of each other.

// File: rtl/ebus_pkg.sv
// Shared types and helpers for the external bus wait-state controller.
// Assumes four chip-select regions and a two-bit software wait code.
package ebus_pkg;
    localparam int NREG = 4;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2
    } bus_phase_t;

    // Translate a software wait code into the number of extra strobe clocks.
    function automatic logic [1:0] sw_wait_len(input logic [1:0] code);
        return (code == 2'b11) ? 2'd3 : code + 2'd1;
    endfunction
endpackage

// File: rtl/ebus_rdy_sync.sv
// Two-flop synchronizer for the ready input.
// Resets to high so that an idle or unused ready reads as "ready".
module ebus_rdy_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_in,
    output logic rdy_s
);
    logic stage1;

    // Shift the raw ready level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= 1'b1;
            rdy_s  <= 1'b1;
        end else begin
            stage1 <= rdy_in;
            rdy_s  <= stage1;
        end
    end
endmodule

// File: rtl/ebus_region_cfg.sv
// Decodes the active region into a chip-select vector and its wait settings.
// Assumes configuration inputs are static while a cycle is running.
module ebus_region_cfg #(
    parameter int NREG = ebus_pkg::NREG,
    localparam int RW  = $clog2(NREG)
) (
    input  logic [RW-1:0]     region,
    input  logic [NREG-1:0]   wait_off,
    input  logic [2*NREG-1:0] wait_cnt,
    output logic [NREG-1:0]   cs_sel,
    output logic              wait_en,
    output logic [1:0]        waits
);
    // One select line per region.
    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign cs_sel[g] = (region == RW'(g));
    end

    // Look up the region's wait enable and software wait length.
    always_comb begin
        wait_en = !wait_off[region];
        waits   = ebus_pkg::sw_wait_len(wait_cnt[2*region +: 2]);
    end
endmodule

// File: rtl/ebus_cycle_fsm.sv
// Sequences one external cycle: idle, setup clock, strobe phase.
// The strobe phase is extended by software waits, then by low ready.
// Assumes AW is at least the region-select width.
module ebus_cycle_fsm #(
    parameter int AW   = 20,
    parameter int DW   = 16,
    parameter int NREG = ebus_pkg::NREG,
    localparam int RW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [1:0]      be,
    input  logic            mux_mode,
    input  logic [DW-1:0]   bus_din,
    input  logic            rdy_s,
    input  logic            wait_en,
    input  logic [1:0]      waits,
    input  logic [NREG-1:0] cs_sel,
    output logic [RW-1:0]   region,
    output logic            in_strobe,
    output logic            done,
    output logic [DW-1:0]   rdata,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_dout,
    output logic            bus_doe,
    output logic [NREG-1:0] cs_n,
    output logic            rd_n,
    output logic            wrl_n,
    output logic            wrh_n,
    output logic            bhe_n,
    output logic            ale
);
    import ebus_pkg::*;

    bus_phase_t    ph;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [1:0]    be_q;
    logic          we_q;
    logic [1:0]    wcnt;
    logic [DW-1:0] addr_lo;

    // Low address bits presented on the data lines in multiplexed setup.
    if (AW >= DW) begin : g_alo_slice
        assign addr_lo = addr_q[DW-1:0];
    end else begin : g_alo_pad
        assign addr_lo = {{(DW-AW){1'b0}}, addr_q};
    end

    assign region = addr_q[AW-1 -: RW];

    // Phase sequencing, wait counting and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            we_q    <= 1'b0;
            wcnt    <= '0;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            case (ph)
                PH_IDLE: if (req) begin
                    addr_q  <= addr;
                    wdata_q <= wdata;
                    be_q    <= be;
                    we_q    <= we;
                    ph      <= PH_SETUP;
                end
                PH_SETUP: begin
                    wcnt <= wait_en ? waits : 2'd0;
                    ph   <= PH_STROBE;
                end
                PH_STROBE: begin
                    if (wcnt != 2'd0) begin
                        wcnt <= wcnt - 2'd1;
                    end else if (!(wait_en && !rdy_s)) begin
                        ph   <= PH_IDLE;
                        done <= 1'b1;
                        if (!we_q) rdata <= bus_din;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Bus output decode from the current phase and the latched request.
    always_comb begin
        in_strobe = (ph == PH_STROBE);
        bus_addr  = addr_q;
        cs_n      = (ph != PH_IDLE) ? ~cs_sel : '1;
        ale       = mux_mode && (ph == PH_SETUP);
        rd_n      = !(in_strobe && !we_q);
        wrl_n     = !(in_strobe && we_q && be_q[0]);
        wrh_n     = !(in_strobe && we_q && be_q[1]);
        bhe_n     = (ph != PH_IDLE) ? !be_q[1] : 1'b1;
        bus_dout  = (ph == PH_SETUP && mux_mode) ? addr_lo : wdata_q;
        case (ph)
            PH_SETUP:  bus_doe = mux_mode || we_q;
            PH_STROBE: bus_doe = we_q;
            default:   bus_doe = 1'b0;
        endcase
    end
endmodule

// File: rtl/ebus_wait_ctrl.sv
// External bus controller for four chip-select regions with software
// and ready-driven wait states, in separate or multiplexed bus form.
// Assumes one system clock per bus phase and static configuration inputs.
module ebus_wait_ctrl #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    be,
    output logic          done,
    output logic [DW-1:0] rdata,
    input  logic          mux_mode,
    input  logic [3:0]    wait_off,
    input  logic [7:0]    wait_cnt,
    input  logic          rdy_in,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    input  logic [DW-1:0] bus_din,
    output logic [3:0]    cs_n,
    output logic          rd_n,
    output logic          wrl_n,
    output logic          wrh_n,
    output logic          bhe_n,
    output logic          ale
);
    localparam int NREG = ebus_pkg::NREG;
    localparam int RW   = $clog2(NREG);

    logic            rdy_s;
    logic [RW-1:0]   region;
    logic [NREG-1:0] cs_sel;
    logic            wait_en;
    logic [1:0]      waits;
    logic            in_strobe;

    ebus_rdy_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rdy_in (rdy_in),
        .rdy_s  (rdy_s)
    );

    ebus_region_cfg #(.NREG(NREG)) u_cfg (
        .region   (region),
        .wait_off (wait_off),
        .wait_cnt (wait_cnt),
        .cs_sel   (cs_sel),
        .wait_en  (wait_en),
        .waits    (waits)
    );

    ebus_cycle_fsm #(.AW(AW), .DW(DW), .NREG(NREG)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .be        (be),
        .mux_mode  (mux_mode),
        .bus_din   (bus_din),
        .rdy_s     (rdy_s),
        .wait_en   (wait_en),
        .waits     (waits),
        .cs_sel    (cs_sel),
        .region    (region),
        .in_strobe (in_strobe),
        .done      (done),
        .rdata     (rdata),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .bus_doe   (bus_doe),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wrl_n     (wrl_n),
        .wrh_n     (wrh_n),
        .bhe_n     (bhe_n),
        .ale       (ale)
    );
endmodule

// File: rtl/ebus_wait_ctrl_chk.sv
// Protocol checker for the external bus controller, bound to the top.
// Assumes reset is held for at least one clock at start-up.
module ebus_wait_ctrl_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          in_strobe,
    input logic [3:0]    wait_off,
    input logic [AW-1:0] bus_addr,
    input logic [3:0]    cs_n,
    input logic          rd_n,
    input logic          wrl_n,
    input logic          wrh_n,
    input logic          bhe_n,
    input logic          ale
);
    logic any_wr;
    logic nowait_reg;
    assign any_wr     = !wrl_n || !wrh_n;
    assign nowait_reg = |(~cs_n & wait_off);

    assert_single_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_nowait_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_strobe && nowait_reg) |=> !in_strobe);

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_strobe && $past(in_strobe)) |-> ($stable(bus_addr) && $stable(cs_n)
            && $stable(rd_n) && $stable(wrl_n) && $stable(wrh_n) && $stable(bhe_n)));

    assert_ale_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && !any_wr));

    assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && any_wr));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n == 4'hF && rd_n && !any_wr));
endmodule

bind ebus_wait_ctrl ebus_wait_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .in_strobe (in_strobe),
    .wait_off  (wait_off),
    .bus_addr  (bus_addr),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wrl_n     (wrl_n),
    .wrh_n     (wrh_n),
    .bhe_n     (bhe_n),
    .ale       (ale)
);

// File: tb/ebus_wait_ctrl_test.sv
module ebus_wait_ctrl_test;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0, bus_din = '0;
    logic [1:0]    be = 2'b11;
    logic          mux_mode = 1'b0;
    logic [3:0]    wait_off = 4'h0;
    logic [7:0]    wait_cnt = 8'h00;
    logic          rdy_in = 1'b1;
    logic          done, bus_doe, rd_n, wrl_n, wrh_n, bhe_n, ale;
    logic [DW-1:0] rdata, bus_dout;
    logic [AW-1:0] bus_addr;
    logic [3:0]    cs_n;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ebus_wait_ctrl #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .be(be), .done(done), .rdata(rdata),
        .mux_mode(mux_mode), .wait_off(wait_off), .wait_cnt(wait_cnt),
        .rdy_in(rdy_in), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .cs_n(cs_n), .rd_n(rd_n),
        .wrl_n(wrl_n), .wrh_n(wrh_n), .bhe_n(bhe_n), .ale(ale)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Software wait length from the requirement's code table (R4).
    function automatic int sw_waits(input logic [1:0] code);
        return (code == 2'b11) ? 3 : int'(code) + 1;
    endfunction

    // Negedge index (1 = first after acceptance) at which done is expected.
    function automatic int exp_done_idx(input bit off, input logic [1:0] code,
                                        input bit rdy_late, input int jr);
        int w, fin;
        w = off ? 0 : sw_waits(code);
        fin = 2 + w;
        if (!off && rdy_late && (jr + 2 > fin)) fin = jr + 2;
        return fin + 1;
    endfunction

    // One full cycle; rdy_late drops ready beforehand and raises it at index jr.
    task automatic run_cycle(input bit wr, input logic [AW-1:0] a,
                             input logic [1:0] bmask, input bit rdy_late,
                             input int jr, input bit poke_req);
        int reg_i, exp_j, j;
        bit off, frozen, seen;
        logic [AW+7:0] snap;
        logic [DW-1:0] din_v;
        reg_i = int'(a[AW-1 -: 2]);
        off   = wait_off[reg_i];
        exp_j = exp_done_idx(off, wait_cnt[2*reg_i +: 2], rdy_late, jr);
        din_v = DW'($urandom);
        if (rdy_late) begin
            rdy_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        @(negedge clk);
        we = wr; addr = a; be = bmask; wdata = DW'($urandom);
        bus_din = din_v; req = 1'b1;
        frozen = 1'b1; seen = 1'b0; snap = '0;
        for (j = 1; j <= 40; j++) begin
            @(negedge clk);
            if (j == 1) req = 1'b0;
            if (poke_req && j == 2) begin req = 1'b1; addr = ~a; end
            if (poke_req && j == 3) req = 1'b0;
            if (rdy_late && j == jr) rdy_in = 1'b1;
            if (j == 1) begin
                check(cs_n == ~(4'b1 << reg_i), "R2 chip select", cs_n, ~(4'b1 << reg_i));
                check(ale == mux_mode, mux_mode ? "R7 ale in setup" : "R8 ale low", ale, mux_mode);
                check(rd_n && wrl_n && wrh_n, "R7 no strobe in setup", {rd_n, wrl_n, wrh_n}, 3'b111);
                if (mux_mode)
                    check(bus_doe && bus_dout == a[DW-1:0], "R7 address on data",
                          {bus_doe, bus_dout}, {1'b1, a[DW-1:0]});
            end
            if (j == 2) begin
                check({rd_n, wrl_n, wrh_n, bhe_n} ==
                      {wr, !(wr && bmask[0]), !(wr && bmask[1]), !bmask[1]},
                      "R9 strobes", {rd_n, wrl_n, wrh_n, bhe_n},
                      {wr, !(wr && bmask[0]), !(wr && bmask[1]), !bmask[1]});
                snap = {bus_addr, cs_n, rd_n, wrl_n, wrh_n, bhe_n};
            end
            if (j > 2 && j < exp_j &&
                {bus_addr, cs_n, rd_n, wrl_n, wrh_n, bhe_n} != snap) frozen = 1'b0;
            if (done) begin seen = 1'b1; break; end
        end
        check(seen && j == exp_j, off ? "R3 no-wait length" : (rdy_late ? "R5 ready wait length" : "R4 software wait length"),
              j, exp_j);
        check(frozen, "R6 outputs held", frozen, 1);
        check(cs_n == 4'hF && rd_n && wrl_n && wrh_n, "R10 release with done",
              {cs_n, rd_n, wrl_n, wrh_n}, 7'h7F);
        if (!wr) check(rdata == din_v, "R10 read capture", rdata, din_v);
        @(negedge clk);
        check(!done, "R10 done one clock", done, 0);
        if (poke_req) begin
            seen = 1'b0;
            repeat (4) begin
                if (cs_n != 4'hF) seen = 1'b1;
                @(negedge clk);
            end
            check(!seen, "R11 busy request ignored", seen, 0);
        end
        rdy_in = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(cs_n == 4'hF && rd_n && wrl_n && wrh_n && bhe_n && !ale && !done,
              "R1 reset outputs", {cs_n, rd_n, wrl_n, wrh_n, bhe_n, ale, done},
              {4'hF, 5'b11110, 1'b0});
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(cs_n == 4'hF && !ale && !done, "R1 idle after reset",
              {cs_n, ale, done}, {4'hF, 2'b00});

        // Directed: no-wait region ignores a late ready (R3).
        wait_off = 4'b0010; wait_cnt = 8'b00_01_10_11; mux_mode = 1'b0;
        run_cycle(1'b0, {2'd1, 16'h1234}, 2'b11, 1'b1, 8, 1'b0);
        // Directed: each wait code with ready held high (R4).
        wait_off = 4'b0000;
        for (int r = 0; r < 4; r++)
            run_cycle(1'b1, {2'(r), 16'h00A5}, 2'b01, 1'b0, 0, 1'b0);
        // Directed: ready released early, at the boundary, and late (R5).
        mux_mode = 1'b1;
        run_cycle(1'b0, {2'd3, 16'h4321}, 2'b10, 1'b1, 1, 1'b0);
        run_cycle(1'b0, {2'd0, 16'h0F0F}, 2'b11, 1'b1, 2, 1'b0);
        run_cycle(1'b1, {2'd2, 16'hBEEF}, 2'b11, 1'b1, 9, 1'b0);
        // Directed: request during a busy cycle (R11).
        run_cycle(1'b1, {2'd1, 16'h5555}, 2'b11, 1'b1, 5, 1'b1);

        for (int n = 0; n < 60; n++) begin
            mux_mode = 1'($urandom);
            wait_off = 4'($urandom);
            wait_cnt = 8'($urandom);
            run_cycle(1'($urandom), AW'($urandom), 2'($urandom_range(1, 3)),
                      1'($urandom), $urandom_range(1, 8), (n % 10) == 3);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule